// File: doc/BRIEF.md
# Palette Lookup Table Builder

This block turns a raw palette, delivered one byte at a time by a display fetch channel, into a colour lookup table. Each table entry is normalized to a transparency flag plus 8-bit red, green and blue. Pixel logic then reads the table by index through a registered lookup port. The number of entries comes from the frame's bits-per-pixel code. The layout of each raw entry comes from a 2-bit format code, and a greyscale switch can override it.

The raw bytes are kept in an internal byte store. When software changes the format code after a palette has been built, the next frame tick rebuilds the table from the stored bytes, so the channel does not have to fetch them again.

The sequencer has four states:
- `ST_IDLE` waits for work. `start` with a valid depth code goes to `ST_LOAD`. `start` with any other depth code goes to `ST_DONE`. A frame tick with a changed format goes to `ST_DECODE`.
- `ST_LOAD` accepts bytes. It moves to `ST_DECODE` once the last byte has been accepted.
- `ST_DECODE` writes one table entry per cycle. It moves to `ST_DONE` after the last entry.
- `ST_DONE` raises `done` for one cycle and then returns to `ST_IDLE`.

Top module: `clut_decoder`

## Requirements
- R1: After reset, every table entry reads as zero, `in_ready` is low and `done` is low.
- R2: The depth code sets the entry count: code 1 gives 4 entries, code 2 gives 16 and code 3 gives 256. `in_ready` is high only until exactly count × entry-size bytes have been accepted.
- R3: A `start` with any other depth code makes `done` rise on the next cycle. No byte is requested and the table is left unchanged.
- R4: Format 0 takes a 16-bit entry. Red comes from bits 15:11, green from 10:5 and blue from 4:0. Each component is left-aligned into 8 bits with zeros below, and transparency is 0.
- R5: Format 1 takes a 32-bit entry. Red comes from bits 23:19, green from 15:10 and blue from 7:3, each left-aligned. Transparency is bit 24.
- R6: Format 2 takes a 32-bit entry. Red comes from bits 23:18, green from 15:10 and blue from 7:2, each left-aligned. Transparency is bit 24.
- R7: Format 3 takes a 32-bit entry. Red comes from bits 23:16, green from 15:8 and blue from 7:0. Transparency is bit 24.
- R8: With `mono_en` high, red, green and blue all equal bits 7:0 of the entry in every format. Transparency still follows R4 to R7.
- R9: Raw entries are little-endian. Entry k starts at byte 2k in format 0 and at byte 4k in the other formats.
- R10: In idle, a `frame_tick` while `pal_fmt` differs from the format of the last build rebuilds the table from the stored bytes, and `done` pulses when the rebuild ends. A tick with the format unchanged does nothing.
- R11: `rd_data` shows the entry at `rd_idx` one clock after the index is presented. Its layout is {transparency, red[7:0], green[7:0], blue[7:0]}.
- R12: `done` is a single-cycle pulse. It comes after the last entry write, so a lookup made after `done` returns the new value. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a load and build |
| frame_tick | input | 1 | Frame boundary; triggers a rebuild if the format changed |
| depth_code | input | 4 | Bits-per-pixel code (1: 2 bpp, 2: 4 bpp, 3: 8 bpp) |
| pal_fmt | input | 2 | Palette format field (configuration bits 16:15) |
| mono_en | input | 1 | Greyscale override |
| in_valid | input | 1 | Raw byte valid |
| in_byte | input | 8 | Raw palette byte |
| in_ready | output | 1 | Raw byte accepted on this edge when valid |
| done | output | 1 | One-cycle pulse after the table is written |
| rd_idx | input | 8 | Lookup index |
| rd_data | output | 25 | Registered entry {t, r, g, b} |

## Verification
The hardest situation to reach is the rebuild from stored bytes. It needs a completed load, then a change of `pal_fmt` while the block is idle, then a frame tick. Only a lookup can show which layout was applied to bytes that were streamed under a different format. The stimulus loads a 32-bit entry in format 3, switches to format 2, ticks, and expects the 6-bit truncation of the same bytes. A second tick with the format unchanged must produce no `done` pulse. The 256-entry depth is covered by a full 512-byte stream whose last entry is then read back.

// File: rtl/clut_pkg.sv
package clut_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_DECODE,
        ST_DONE
    } seq_state_t;

    localparam int ENTRY_W = 25;

    // raw = {byte3[0], byte2, byte1, byte0}; result = {t, r, g, b}
    function automatic logic [ENTRY_W-1:0] decode_entry(
        input logic [1:0]         fmt,
        input logic               mono,
        input logic [ENTRY_W-1:0] raw
    );
        logic       t;
        logic [7:0] r, g, b;
        t = (fmt == 2'd0) ? 1'b0 : raw[24];
        unique case (fmt)
            2'd0: begin
                r = {raw[15:11], 3'b000};
                g = {raw[10:5],  2'b00};
                b = {raw[4:0],   3'b000};
            end
            2'd1: begin
                r = {raw[23:19], 3'b000};
                g = {raw[15:10], 2'b00};
                b = {raw[7:3],   3'b000};
            end
            2'd2: begin
                r = {raw[23:18], 2'b00};
                g = {raw[15:10], 2'b00};
                b = {raw[7:2],   2'b00};
            end
            default: begin
                r = raw[23:16];
                g = raw[15:8];
                b = raw[7:0];
            end
        endcase
        if (mono) begin
            r = raw[7:0];
            g = raw[7:0];
            b = raw[7:0];
        end
        return {t, r, g, b};
    endfunction

endpackage

// File: rtl/clut_raw_store.sv
module clut_raw_store #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] base,
    output logic [24:0]   rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // four consecutive bytes from an aligned base, little-endian
    logic [7:0] byte_at [4];
    for (genvar k = 0; k < 4; k++) begin : g_tap
        assign byte_at[k] = mem[base + AW'(k)];
    end

    assign rdata = {byte_at[3][0], byte_at[2], byte_at[1], byte_at[0]};
endmodule

// File: rtl/clut_table.sv
module clut_table #(
    parameter int ENTRIES = 256,
    parameter int WIDTH   = 25,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            if (we) mem[waddr] <= wdata;
            rdata <= mem[raddr];
        end
    end

    // R11: a settled index gives a settled result once no write is in flight
    a_r11_read_settles: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(raddr) && !we && !$past(we)) |=> $stable(rdata));
endmodule

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IW = 8,
    parameter int BW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          frame_tick,
    input  logic [3:0]    depth_code,
    input  logic [1:0]    pal_fmt,
    input  logic          mono_en,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          byte_we,
    output logic [BW-1:0] byte_addr,
    output logic          ent_we,
    output logic [IW-1:0] ent_idx,
    output logic [1:0]    cur_fmt,
    output logic          cur_mono,
    output logic          done
);
    seq_state_t    state, state_nx;
    logic [BW-1:0] byte_cnt;
    logic [IW-1:0] ent_cnt, n_m1;
    logic [1:0]    fmt_q, used_fmt;
    logic          mono_q, loaded;

    logic          dvalid;
    logic [IW-1:0] dn_m1;
    always_comb begin
        dvalid = 1'b1;
        unique case (depth_code)
            4'd1:    dn_m1 = IW'(3);
            4'd2:    dn_m1 = IW'(15);
            4'd3:    dn_m1 = IW'(255);
            default: begin dn_m1 = '0; dvalid = 1'b0; end
        endcase
    end

    logic [BW-1:0] need_m1;
    assign need_m1 = (fmt_q == 2'd0) ? BW'({n_m1, 1'b1}) : BW'({n_m1, 2'b11});

    logic accept, last_byte, last_ent, redo;
    assign accept    = (state == ST_LOAD) && in_valid;
    assign last_byte = accept && (byte_cnt == need_m1);
    assign last_ent  = (state == ST_DECODE) && (ent_cnt == n_m1);
    assign redo      = !start && frame_tick && loaded && (pal_fmt != used_fmt);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = dvalid ? ST_LOAD : ST_DONE;
                       else if (redo) state_nx = ST_DECODE;
            ST_LOAD:   if (last_byte) state_nx = ST_DECODE;
            ST_DECODE: if (last_ent) state_nx = ST_DONE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_cnt <= '0;
            ent_cnt  <= '0;
            n_m1     <= '0;
            fmt_q    <= '0;
            used_fmt <= '0;
            mono_q   <= 1'b0;
            loaded   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start && dvalid) begin
                        n_m1     <= dn_m1;
                        fmt_q    <= pal_fmt;
                        mono_q   <= mono_en;
                        byte_cnt <= '0;
                    end else if (!start && redo) begin
                        fmt_q    <= pal_fmt;
                        mono_q   <= mono_en;
                        used_fmt <= pal_fmt;
                        ent_cnt  <= '0;
                    end
                end
                ST_LOAD: begin
                    if (accept) byte_cnt <= byte_cnt + 1'b1;
                    if (last_byte) begin
                        ent_cnt  <= '0;
                        used_fmt <= fmt_q;
                    end
                end
                ST_DECODE: begin
                    ent_cnt <= ent_cnt + 1'b1;
                    if (last_ent) loaded <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        in_ready  = (state == ST_LOAD);
        byte_we   = accept;
        byte_addr = byte_cnt;
        ent_we    = (state == ST_DECODE);
        ent_idx   = ent_cnt;
        cur_fmt   = fmt_q;
        cur_mono  = mono_q;
        done      = (state == ST_DONE);
    end

    a_r2_load_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid && byte_cnt == need_m1) |=> (ent_we && !in_ready));
    a_r3_bad_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !dvalid) |=> (done && !ent_we));
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_we && start && ent_cnt != n_m1) |=> ent_we);
    a_r10_rebuild: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && redo) |=> (ent_we && cur_fmt == $past(pal_fmt)));
endmodule

// File: rtl/clut_decoder.sv
module clut_decoder
    import clut_pkg::*;
#(
    parameter int MAX_ENTRIES = 256,
    localparam int IW = $clog2(MAX_ENTRIES),
    localparam int BW = $clog2(MAX_ENTRIES * 4)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               frame_tick,
    input  logic [3:0]         depth_code,
    input  logic [1:0]         pal_fmt,
    input  logic               mono_en,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    output logic               in_ready,
    output logic               done,
    input  logic [IW-1:0]      rd_idx,
    output logic [ENTRY_W-1:0] rd_data
);
    logic          byte_we, ent_we, cur_mono;
    logic [BW-1:0] byte_addr, ent_base;
    logic [IW-1:0] ent_idx;
    logic [1:0]    cur_fmt;
    logic [24:0]   raw_word;
    logic [ENTRY_W-1:0] ent_val;

    clut_seq #(.IW(IW), .BW(BW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .frame_tick (frame_tick),
        .depth_code (depth_code),
        .pal_fmt    (pal_fmt),
        .mono_en    (mono_en),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .byte_we    (byte_we),
        .byte_addr  (byte_addr),
        .ent_we     (ent_we),
        .ent_idx    (ent_idx),
        .cur_fmt    (cur_fmt),
        .cur_mono   (cur_mono),
        .done       (done)
    );

    assign ent_base = (cur_fmt == 2'd0) ? BW'({ent_idx, 1'b0}) : BW'({ent_idx, 2'b00});

    clut_raw_store #(.DEPTH(MAX_ENTRIES * 4)) u_raw (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (byte_we),
        .waddr (byte_addr),
        .wdata (in_byte),
        .base  (ent_base),
        .rdata (raw_word)
    );

    assign ent_val = decode_entry(cur_fmt, cur_mono, raw_word);

    clut_table #(.ENTRIES(MAX_ENTRIES), .WIDTH(ENTRY_W)) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ent_we),
        .waddr (ent_idx),
        .wdata (ent_val),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    // R4: a format 0 entry never carries transparency into the table
    a_r4_no_transp: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_we && cur_fmt == 2'd0) |-> !ent_val[24]);
endmodule

// File: tb/tb_clut_decoder.sv
module tb_clut_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, frame_tick = 1'b0, mono_en = 1'b0;
    logic [3:0]  depth_code = '0;
    logic [1:0]  pal_fmt = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_ready, done;
    logic [7:0]  rd_idx = '0;
    logic [24:0] rd_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] img [1024];

    always #10 clk = ~clk;

    clut_decoder dut (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_tick(frame_tick),
        .depth_code(depth_code), .pal_fmt(pal_fmt), .mono_en(mono_en),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .done(done), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // {fmt[1:0], mono, raw[31:0], expected[24:0]}
    localparam logic [59:0] VEC [9] = '{
        {2'd0, 1'b0, 32'h0000F81F, 25'h0F800F8},
        {2'd0, 1'b0, 32'h000007E0, 25'h000FC00},
        {2'd0, 1'b1, 32'h0000AB5C, 25'h05C5C5C},
        {2'd1, 1'b0, 32'h00FFFFFF, 25'h0F8FCF8},
        {2'd1, 1'b1, 32'h01000077, 25'h1777777},
        {2'd2, 1'b0, 32'h01FFFFFF, 25'h1FCFCFC},
        {2'd2, 1'b0, 32'h00845A3C, 25'h084583C},
        {2'd3, 1'b0, 32'h01123456, 25'h1123456},
        {2'd3, 1'b1, 32'h00AABBCC, 25'h0CCCCCC}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 1024; i++) img[i] = '0;
    endtask

    task automatic put_entry(int idx, int size, logic [31:0] raw);
        for (int k = 0; k < size; k++) img[idx * size + k] = raw[8*k +: 8];
    endtask

    task automatic stream(int nbytes);
        int k = 0;
        int guard = 0;
        while (k < nbytes && guard < 5000) begin
            in_valid = 1'b1;
            in_byte  = img[k];
            if (in_ready) k++;
            @(negedge clk);
            guard++;
        end
        in_valid = 1'b0;
    endtask

    task automatic wait_done(string req);
        int g = 0;
        while (!done && g < 2000) begin
            @(negedge clk);
            g++;
        end
        chk(req, {31'd0, done}, 32'd1);
        @(negedge clk);
        chk("R12 done single cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic run_load(int depth, int fmt, int mono, int nbytes);
        depth_code = 4'(depth);
        pal_fmt    = 2'(fmt);
        mono_en    = mono[0];
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        stream(nbytes);
    endtask

    task automatic look(int idx, string req, logic [24:0] exp);
        rd_idx = 8'(idx);
        @(negedge clk);
        chk(req, {7'd0, rd_data}, {7'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready after reset", {31'd0, in_ready}, 32'd0);
        chk("R1 done after reset", {31'd0, done}, 32'd0);
        look(0, "R1 entry 0 cleared", 25'd0);
        look(255, "R1 entry 255 cleared", 25'd0);

        // R4 R5 R6 R7 R8 R9 vector walk, 2 bpp palette
        foreach (VEC[v]) begin
            int fmt, sz;
            fmt = int'(VEC[v][59:58]);
            sz  = (fmt == 0) ? 2 : 4;
            clear_img();
            put_entry(2, sz, VEC[v][56:25]);
            run_load(1, fmt, int'(VEC[v][57]), 4 * sz);
            wait_done("R12 done after load");
            look(2, "R4-R8 decoded entry", VEC[v][24:0]);
            look(1, "R9 neighbour entry untouched by offset", 25'd0);
        end

        // R11 latency: value appears exactly one clock after the index
        rd_idx = 8'd2;
        @(negedge clk);
        rd_idx = 8'd1;
        @(posedge clk);
        #1;
        chk("R11 one-cycle latency", {7'd0, rd_data}, 32'd0);

        // R10 rebuild from stored bytes with a new format
        clear_img();
        put_entry(2, 4, 32'h01123456);
        run_load(1, 3, 0, 16);
        wait_done("R10 initial load");
        look(2, "R7 before rebuild", 25'h1123456);
        pal_fmt = 2'd2;
        @(negedge clk);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        wait_done("R10 rebuild done");
        look(2, "R10 rebuilt as format 2", 25'h1103454);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        begin
            int seen = 0;
            for (int c = 0; c < 10; c++) begin
                if (done) seen++;
                @(negedge clk);
            end
            chk("R10 unchanged format no rebuild", 32'(seen), 32'd0);
        end

        // R3 unsupported depth
        depth_code = 4'd0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R3 done next cycle", {31'd0, done}, 32'd1);
        chk("R3 no request", {31'd0, in_ready}, 32'd0);
        look(2, "R3 table unchanged", 25'h1103454);

        // R2 16 entries, format 3
        clear_img();
        for (int i = 0; i < 16; i++)
            put_entry(i, 4, {7'd0, 1'(i), 8'(8'h80 + i), 8'(8'h40 + i), 8'(i)});
        run_load(2, 3, 0, 64);
        chk("R2 ready drops after 64 bytes", {31'd0, in_ready}, 32'd0);
        wait_done("R2 done 16 entries");
        look(15, "R2 entry 15", 25'h18F4F0F);
        look(6, "R2 entry 6", 25'h0864606);

        // R2 256 entries, format 0 greyscale
        clear_img();
        for (int i = 0; i < 256; i++) put_entry(i, 2, {16'd0, 8'(~i), 8'(i)});
        run_load(3, 0, 1, 512);
        chk("R2 ready drops after 512 bytes", {31'd0, in_ready}, 32'd0);
        wait_done("R2 done 256 entries");
        look(200, "R2 R8 entry 200", 25'h0C8C8C8);
        look(255, "R2 entry 255", 25'h0FFFFFF);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule